// File: doc/BRIEF.md
# GPIO port with per-line interrupt routing

This block is a memory-mapped general-purpose I/O port of `NLINES` lines (1 to 32). Software reaches it through a plain register bus with a byte address, a write strobe, 32-bit write data and combinational read data. Each line can be set as an input or as an output. An output line drives the value held in the output register. The data register always returns the sampled pin value, whatever the direction.

Each line passes through a two-stage synchroniser. Its interrupt condition can be set to one of four modes: low level, high level, falling edge or rising edge. The mode comes from a polarity bit and an edge bit, and an interrupt mask bit gates the result.

A routing byte per line selects which of `NOUTS` interrupt wires the line drives, or none. Each interrupt wire is the OR of every unmasked, active line that is routed to it. The register bus is a control path, so it has no handshake. A write takes effect at the clock edge on which `bus_wr` is high.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset the output, direction, mask, polarity, edge and spare (0x18) registers read 0. Every map byte reads 0x80. `pin_out`, `pin_oe` and `irq_out` are all 0.
- R2: The registers at 0x04 (output), 0x08 (direction), 0x0C (mask), 0x10 (polarity), 0x14 (edge) and 0x18 (spare) hold bits [NLINES-1:0] of the written word and read back those bits. Bits at and above NLINES read 0.
- R3: `pin_out` equals the output register and `pin_oe` equals the direction register, both from the cycle after the write. A direction bit of 1 means the line drives its pin.
- R4: A read of 0x00 returns the pin value from two clock edges earlier, for either direction. Writes to 0x00 are ignored.
- R5: With edge bit 0, polarity 0 gives a low-level interrupt and polarity 1 gives a high-level interrupt. The line's output wire is high while the synchronised pin is at the active level, starting two clock edges after the pin changes.
- R6: With edge bit 1, polarity 1 gives a rising-edge interrupt and polarity 0 gives a falling-edge interrupt. The matching pin transition raises the routed wire for exactly one cycle, two edges after the change. The opposite transition raises nothing.
- R7: A line whose mask bit is 0 never raises any interrupt wire.
- R8: The routing map starts at 0x20 with one byte per line, four lines per word. Line 4k+j sits in bits [31-8j:24-8j] of the word at 0x20+4k, so line 0 is the most significant byte. A byte with bit 7 clear routes the line to wire `byte[6:0]`. A byte with bit 7 set, or with an index of NOUTS or more, routes it nowhere. Map bytes read back as written.
- R9: Several lines routed to the same wire are ORed onto it. Lines on different wires do not affect each other.
- R10: Reads of addresses that hold no register return 0. Writes to those addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NLINES | Raw pin levels, asynchronous |
| pin_out | output | NLINES | Output register value towards the pads |
| pin_oe | output | NLINES | Drive enable per line (direction register) |
| irq_out | output | NOUTS | Routed interrupt wires |

## Verification
A corrupted configuration register shows up directly at the ports. A bad direction or output bit appears on `pin_oe` or `pin_out` in the cycle after the write. A bad mask, polarity, edge or map byte makes the wrong wire fire, or no wire fire, two edges after the stimulating pin change. A fault in the synchroniser or the previous-sample stage shifts the data-register value by a cycle. It also turns an edge pulse into a level, or drops it, and this is visible in the cycle the pulse is due. The bench sweeps every line through every mode against every routing choice, so a fault in the placement of a single byte or bit in the map cannot hide.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned OFS_DATA = 'h00;
  localparam int unsigned OFS_OUT  = 'h04;
  localparam int unsigned OFS_DIR  = 'h08;
  localparam int unsigned OFS_MASK = 'h0C;
  localparam int unsigned OFS_POL  = 'h10;
  localparam int unsigned OFS_EDGE = 'h14;
  localparam int unsigned OFS_SPR  = 'h18;
  localparam int unsigned OFS_MAP  = 'h20;
  localparam logic [7:0]  MAP_NONE = 8'h80;

  // Interrupt condition of one line from its current and previous samples.
  function automatic logic line_hit(input logic cur, input logic prev,
                                    input logic pol, input logic edge_sel);
    logic lvl;
    lvl = pol ? cur : ~cur;
    return edge_sel ? (lvl & (cur ^ prev)) : lvl;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] samp,
  output logic [NLINES-1:0] prev
);
  logic [NLINES-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      samp <= '0;
      prev <= '0;
    end else begin
      meta <= pin_in;
      samp <= meta;
      prev <= samp;
    end
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic [31:0]         wdata,
  input  logic [NLINES-1:0]   samp,
  output logic [31:0]         rdata,
  output logic [NLINES-1:0]   out_q,
  output logic [NLINES-1:0]   dir_q,
  output logic [NLINES-1:0]   mask_q,
  output logic [NLINES-1:0]   pol_q,
  output logic [NLINES-1:0]   edge_q,
  output logic [NLINES*8-1:0] map_q
);
  localparam int NWORDS = (NLINES + 3) / 4;

  logic [NLINES-1:0] spr_q;
  logic              map_hit;
  int                map_word;

  always_comb begin
    map_word = int'(addr) - int'(OFS_MAP);
    map_hit  = (addr[1:0] == 2'b00) && (map_word >= 0) && ((map_word >> 2) < NWORDS);
    map_word = map_word >> 2;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      mask_q <= '0;
      pol_q  <= '0;
      edge_q <= '0;
      spr_q  <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(OFS_OUT))  out_q  <= wdata[NLINES-1:0];
      if (addr == ADDR_W'(OFS_DIR))  dir_q  <= wdata[NLINES-1:0];
      if (addr == ADDR_W'(OFS_MASK)) mask_q <= wdata[NLINES-1:0];
      if (addr == ADDR_W'(OFS_POL))  pol_q  <= wdata[NLINES-1:0];
      if (addr == ADDR_W'(OFS_EDGE)) edge_q <= wdata[NLINES-1:0];
      if (addr == ADDR_W'(OFS_SPR))  spr_q  <= wdata[NLINES-1:0];
    end
  end

  for (genvar g = 0; g < NLINES; g++) begin : g_map
    localparam int SH = (3 - (g % 4)) * 8;
    always_ff @(posedge clk) begin
      if (!rst_n)
        map_q[g*8 +: 8] <= MAP_NONE;
      else if (wr_en && map_hit && map_word == g / 4)
        map_q[g*8 +: 8] <= wdata[SH +: 8];
    end
  end

  always_comb begin
    rdata = '0;
    if (map_hit) begin
      for (int g = 0; g < NLINES; g++)
        if (g / 4 == map_word) rdata[(3 - (g % 4)) * 8 +: 8] = map_q[g*8 +: 8];
    end else if (addr == ADDR_W'(OFS_DATA)) rdata[NLINES-1:0] = samp;
    else if (addr == ADDR_W'(OFS_OUT))  rdata[NLINES-1:0] = out_q;
    else if (addr == ADDR_W'(OFS_DIR))  rdata[NLINES-1:0] = dir_q;
    else if (addr == ADDR_W'(OFS_MASK)) rdata[NLINES-1:0] = mask_q;
    else if (addr == ADDR_W'(OFS_POL))  rdata[NLINES-1:0] = pol_q;
    else if (addr == ADDR_W'(OFS_EDGE)) rdata[NLINES-1:0] = edge_q;
    else if (addr == ADDR_W'(OFS_SPR))  rdata[NLINES-1:0] = spr_q;
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NLINES = 32
) (
  input  logic [NLINES-1:0] samp,
  input  logic [NLINES-1:0] prev,
  input  logic [NLINES-1:0] pol_q,
  input  logic [NLINES-1:0] edge_q,
  input  logic [NLINES-1:0] mask_q,
  output logic [NLINES-1:0] req
);
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    assign req[g] = mask_q[g] & line_hit(samp[g], prev[g], pol_q[g], edge_q[g]);
  end
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route #(
  parameter int NLINES = 32,
  parameter int NOUTS  = 4
) (
  input  logic [NLINES-1:0]   req,
  input  logic [NLINES*8-1:0] map_q,
  output logic [NOUTS-1:0]    irq_out
);
  for (genvar k = 0; k < NOUTS; k++) begin : g_out
    always_comb begin
      irq_out[k] = 1'b0;
      for (int g = 0; g < NLINES; g++)
        if (req[g] && !map_q[g*8+7] && map_q[g*8 +: 7] == 7'(k))
          irq_out[k] = 1'b1;
    end
  end
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router #(
  parameter int NLINES = 32,
  parameter int NOUTS  = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] pin_out,
  output logic [NLINES-1:0] pin_oe,
  output logic [NOUTS-1:0]  irq_out
);
  logic [NLINES-1:0]   samp, prev, mask_q, pol_q, edge_q, req;
  logic [NLINES*8-1:0] map_q;

  gpio_sync #(.NLINES(NLINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .samp(samp), .prev(prev));

  gpio_regs #(.NLINES(NLINES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr_en(bus_wr),
    .wdata(bus_wdata), .samp(samp), .rdata(bus_rdata), .out_q(pin_out),
    .dir_q(pin_oe), .mask_q(mask_q), .pol_q(pol_q), .edge_q(edge_q),
    .map_q(map_q));

  gpio_irq_detect #(.NLINES(NLINES)) u_detect (
    .samp(samp), .prev(prev), .pol_q(pol_q), .edge_q(edge_q),
    .mask_q(mask_q), .req(req));

  gpio_irq_route #(.NLINES(NLINES), .NOUTS(NOUTS)) u_route (
    .req(req), .map_q(map_q), .irq_out(irq_out));
endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk
  import gpio_irq_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int NOUTS  = 4,
  parameter int ADDR_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wr,
  input logic [31:0]         bus_wdata,
  input logic [NLINES-1:0]   pin_out,
  input logic [NLINES-1:0]   pin_oe,
  input logic [NOUTS-1:0]    irq_out,
  input logic [NLINES-1:0]   mask_q,
  input logic [NLINES-1:0]   edge_q,
  input logic [NLINES-1:0]   samp,
  input logic [NLINES*8-1:0] map_q
);
  logic none_routed;
  always_comb begin
    none_routed = 1'b1;
    for (int g = 0; g < NLINES; g++) none_routed &= map_q[g*8+7];
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (pin_out == '0 && pin_oe == '0 && irq_out == '0));

  assert_dir_drives_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_DIR)) |=> pin_oe == $past(bus_wdata[NLINES-1:0]));

  assert_out_drives_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_OUT)) |=> pin_out == $past(bus_wdata[NLINES-1:0]));

  assert_edge_needs_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (&edge_q && $stable(samp)) |-> irq_out == '0);

  assert_masked_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> irq_out == '0);

  assert_unrouted_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    none_routed |-> irq_out == '0);
endmodule

bind gpio_irq_router gpio_irq_router_chk #(
  .NLINES(NLINES), .NOUTS(NOUTS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .irq_out(irq_out), .mask_q(mask_q), .edge_q(edge_q), .samp(samp),
  .map_q(map_q));

// File: tb/gpio_irq_router_tb.sv
`timescale 1ns/1ps
module gpio_irq_router_tb;
  localparam int NL = 8;
  localparam int NO = 3;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] pin_in = '0;
  logic [NL-1:0] pin_out, pin_oe;
  logic [NO-1:0] irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  gpio_irq_router #(.NLINES(NL), .NOUTS(NO), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out));

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  function automatic logic [31:0] map_word(input int w, input int line, input logic [7:0] rt);
    logic [31:0] m = 32'h80808080;
    if (line / 4 == w) m[(3 - line % 4) * 8 +: 8] = rt;
    return m;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] offs [6] = '{8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18};
    logic [7:0] routes [5] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h80};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    foreach (offs[i]) chk_rd("R1", offs[i], 32'h0);
    chk_rd("R1", 8'h20, 32'h80808080);
    chk_rd("R1", 8'h24, 32'h80808080);
    chk("R1", {29'h0, irq_out}, 32'h0);
    chk("R1", {pin_oe, pin_out}, 32'h0);

    // R2 readback width, R3 pin outputs
    foreach (offs[i]) begin
      wr(offs[i], 32'hA5C3_965A);
      chk_rd("R2", offs[i], 32'h0000_005A);
      wr(offs[i], 32'hFFFF_FF81);
      chk_rd("R2", offs[i], 32'h0000_0081);
      if (offs[i] == 8'h04) chk("R3", {24'h0, pin_out}, 32'h81);
      if (offs[i] == 8'h08) chk("R3", {24'h0, pin_oe}, 32'h81);
      wr(offs[i], 32'h0);
    end
    chk("R3", {pin_oe, pin_out}, 32'h0);

    // R10 unmapped addresses
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h22, 32'hFFFF_FFFF);
    chk_rd("R10", 8'h1C, 32'h0);
    chk_rd("R10", 8'h40, 32'h0);
    chk_rd("R10", 8'h28, 32'h0);
    chk_rd("R10", 8'h20, 32'h80808080);
    foreach (offs[i]) chk_rd("R10", offs[i], 32'h0);

    // R8 map readback
    wr(8'h20, 32'h0102_8003);
    chk_rd("R8", 8'h20, 32'h0102_8003);
    wr(8'h20, 32'h8080_8080);

    // R4 data register sweep, both directions
    for (int dv = 0; dv < 2; dv++) begin
      logic [7:0] old;
      wr(8'h08, dv ? 32'hFF : 32'h0);
      old = pin_in;
      for (int p = 0; p < 256; p++) begin
        pin_in = p[7:0];
        tick();
        chk_rd("R4", 8'h00, {24'h0, old});
        tick();
        chk_rd("R4", 8'h00, p);
        old = p[7:0];
      end
    end
    wr(8'h00, 32'h0000_0000);
    chk_rd("R4", 8'h00, 32'hFF);
    wr(8'h08, 32'h0);

    // R5 R6 R7 R8 per-line mode/route sweep
    for (int line = 0; line < NL; line++) begin
      for (int mode = 0; mode < 4; mode++) begin
        for (int r = 0; r < 5; r++) begin
          logic pol, edg;
          logic [NO-1:0] exp;
          string tag;
          pol = mode[0]; edg = mode[1];
          tag = edg ? "R6" : "R5";
          exp = (routes[r] < NO) ? NO'(1 << routes[r]) : '0;
          wr(8'h0C, 32'h0);
          pin_in = {NL{~pol}};
          repeat (3) tick();
          wr(8'h10, pol ? (32'h1 << line) : 32'h0);
          wr(8'h14, edg ? (32'h1 << line) : 32'h0);
          wr(8'h20, map_word(0, line, routes[r]));
          wr(8'h24, map_word(1, line, routes[r]));
          wr(8'h0C, 32'h1 << line);
          chk(tag, {29'h0, irq_out}, 32'h0);
          pin_in[line] = pol;
          tick();
          chk(tag, {29'h0, irq_out}, 32'h0);
          tick();
          chk(routes[r] < NO ? tag : "R8", {29'h0, irq_out}, {29'h0, exp});
          tick();
          chk(tag, {29'h0, irq_out}, edg ? 32'h0 : {29'h0, exp});
          pin_in[line] = ~pol;
          tick(); tick();
          chk(tag, {29'h0, irq_out}, 32'h0);
          tick();
          chk(tag, {29'h0, irq_out}, 32'h0);
          if (r == 0) begin
            wr(8'h0C, 32'h0);
            pin_in[line] = pol;
            tick(); tick();
            chk("R7", {29'h0, irq_out}, 32'h0);
            tick();
            chk("R7", {29'h0, irq_out}, 32'h0);
            pin_in[line] = ~pol;
            repeat (3) tick();
          end
        end
      end
    end

    // R9 shared wires: lines 0,5 -> wire 1, line 2 -> wire 2, high level
    wr(8'h0C, 32'h0);
    pin_in = '0;
    repeat (3) tick();
    wr(8'h10, 32'h25);
    wr(8'h14, 32'h0);
    wr(8'h20, 32'h0180_0280);
    wr(8'h24, 32'h8001_8080);
    wr(8'h0C, 32'h25);
    chk("R9", {29'h0, irq_out}, 32'h0);
    pin_in = 8'h01; tick(); tick();
    chk("R9", {29'h0, irq_out}, 32'h2);
    pin_in = 8'h20; tick(); tick();
    chk("R9", {29'h0, irq_out}, 32'h2);
    pin_in = 8'h04; tick(); tick();
    chk("R9", {29'h0, irq_out}, 32'h4);
    pin_in = 8'h25; tick(); tick();
    chk("R9", {29'h0, irq_out}, 32'h6);
    pin_in = 8'hDA; tick(); tick();
    chk("R9", {29'h0, irq_out}, 32'h0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule